// File: doc/BRIEF.md
# Context-Qualified First-Level Cache Hit Check

This block decides hit, miss, fault or pass-through for a direct-mapped first-level cache. Each line keeps its access rights, worked out when the line was filled, and the execution context in force at that time: privilege level, instruction-set mode, address-space identifier and an 8-bit digest of the 64-bit keyring register. A lookup hits only when the line is valid, its tag matches, and every stored context field equals the current one. Any change of context therefore turns old lines into misses, and stale rights are never used. Data storage, replacement and refill are outside this block.

Lookups travel on a valid/ready request channel and come back on a valid/ready response channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its response appears on the next edge and is held, with its fields unchanged, until a rising edge where `resp_ready` is high. `req_ready` is high whenever no response is waiting or the waiting response is being taken in the same cycle, so there is one response slot and no other buffering. The fill port is a plain strobe that is always taken. It captures the current context inputs together with the flags and line address it is given.

Top module: `ctx_l1_hitchk`

## Requirements
- R1: After reset `resp_valid` is low, `req_ready` is high, and every line is invalid, so the first lookup to any address returns a miss (hit, fault and uncached all low).
- R2: The line address splits into index = bits [5:0] and tag = bits [25:6]. A lookup hits only on a valid line whose stored tag equals the request tag. A different tag at the same index, or an index never filled, misses.
- R3: Privilege is encoded 0 = user, 1 = supervisor, 2 = interrupt. A lookup misses when the current privilege differs from the one captured at fill.
- R4: The keyring digest is the XOR of the eight bytes of `cur_keyring`. A lookup misses when the digest differs from the one captured at fill, and still hits when the keyring changes but its digest does not.
- R5: A lookup misses when either the current instruction-set mode or the current address-space identifier differs from the value captured at fill.
- R6: Flag bits set to 1 forbid: bit0 read, bit1 write, bit2 fetch. Request kind encodes 0 = read, 1 = write, 2 = fetch, 3 = read. A matching lookup whose kind is forbidden reports fault high and hit low. A permitted kind on the same line hits.
- R7: Flag bit3 forbids user privilege. A matching user-privilege lookup on such a line faults for any kind. A supervisor lookup on a line with the same flags hits.
- R8: Flag bit4 marks a line uncacheable. A matching lookup on it reports uncached high with hit and fault low, even when other flag bits would forbid the access.
- R9: While a response is waiting and `resp_ready` is low, `req_ready` is low, and `resp_valid` and the response fields stay unchanged.
- R10: A fill writes tag, context and flags in one cycle, replacing the line at its index. A lookup accepted on the same edge as a fill sees the line as it was before that fill.
- R11: A response is presented on the edge after its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_line | input | 26 | Line address of the lookup |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 interrupt |
| cur_isa | input | 2 | Current instruction-set mode |
| cur_asid | input | 16 | Current address-space identifier |
| cur_keyring | input | 64 | Current keyring register |
| fill_en | input | 1 | Write a line this cycle |
| fill_line | input | 26 | Line address being filled |
| fill_flags | input | 5 | Deny flags for the filled line |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken this cycle |
| resp_hit | output | 1 | Access hits and data may be returned |
| resp_fault | output | 1 | Access matched a line but is forbidden |
| resp_uncached | output | 1 | Access matched an uncacheable line and must bypass |

## Verification
The hardest case to reach from the ports is a fill and a lookup to the same index on the same edge. The lookup must see the old line, and the write must still land. The bench drives both strobes together in one cycle, with the fill changing the tag, and then checks the old-tag result followed by a new-tag hit. The digest-preserving keyring change is reached by filling under one keyring and looking up under a byte-swapped copy with the same XOR. Back-pressure is exercised by holding `resp_ready` low across several cycles while a second request waits.

// File: rtl/ctxl1_pkg.sv
package ctxl1_pkg;
  localparam int FLAG_W = 5;
  localparam int FL_NRD = 0;
  localparam int FL_NWR = 1;
  localparam int FL_NEX = 2;
  localparam int FL_NUS = 3;
  localparam int FL_NCA = 4;

  localparam logic [1:0] PRIV_USER = 2'd0;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_READ2 = 2'd3
  } acc_e;

  function automatic logic kind_denied(input logic [1:0] kind, input logic [FLAG_W-1:0] fl);
    case (acc_e'(kind))
      ACC_WRITE: kind_denied = fl[FL_NWR];
      ACC_FETCH: kind_denied = fl[FL_NEX];
      default:   kind_denied = fl[FL_NRD];
    endcase
  endfunction
endpackage

// File: rtl/ctx_keyfold.sv
module ctx_keyfold #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  key_i,
  output logic [OUT_W-1:0] digest_o
);
  localparam int LANES = IN_W / OUT_W;

  logic [OUT_W-1:0] acc [LANES+1];
  assign acc[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc[g+1] = acc[g] ^ key_i[g*OUT_W +: OUT_W];
  end

  assign digest_o = acc[LANES];
endmodule

// File: rtl/ctx_line_store.sv
module ctx_line_store #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 20,
  parameter int CTX_W  = 28,
  parameter int FLAG_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [CTX_W-1:0]         wr_ctx,
  input  logic [FLAG_W-1:0]        wr_flags,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [CTX_W-1:0]         rd_ctx,
  output logic [FLAG_W-1:0]        rd_flags
);
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [CTX_W-1:0]  ctx_q  [LINES];
  logic [FLAG_W-1:0] flg_q  [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ctx_q[wr_idx] <= wr_ctx;
      flg_q[wr_idx] <= wr_flags;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_ctx   = ctx_q[rd_idx];
  assign rd_flags = flg_q[rd_idx];

  // R10: a fill leaves its line valid with the written tag
  p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/ctx_hit_eval.sv
module ctx_hit_eval
  import ctxl1_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int CTX_W = 28
) (
  input  logic              line_valid,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [CTX_W-1:0]  line_ctx,
  input  logic [FLAG_W-1:0] line_flags,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  output logic              hit_o,
  output logic              fault_o,
  output logic              uncached_o
);
  logic match, deny, bypass;

  always_comb begin
    match  = line_valid && (line_tag == req_tag) && (line_ctx == req_ctx);
    deny   = kind_denied(req_kind, line_flags) ||
             ((req_priv == PRIV_USER) && line_flags[FL_NUS]);
    bypass = line_flags[FL_NCA];
    uncached_o = match && bypass;
    fault_o    = match && !bypass && deny;
    hit_o      = match && !bypass && !deny;
  end
endmodule

// File: rtl/ctx_l1_hitchk.sv
module ctx_l1_hitchk
  import ctxl1_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int LINE_W = 26,
  parameter int ISA_W  = 2,
  parameter int ASID_W = 16,
  parameter int KEY_W  = 64,
  parameter int HASH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        cur_priv,
  input  logic [ISA_W-1:0]  cur_isa,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [KEY_W-1:0]  cur_keyring,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [4:0]        fill_flags,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic              resp_fault,
  output logic              resp_uncached
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam int CTX_W = 2 + ISA_W + ASID_W + HASH_W;

  logic [HASH_W-1:0] key_digest;
  logic [CTX_W-1:0]  cur_ctx;
  logic              ln_valid;
  logic [TAG_W-1:0]  ln_tag;
  logic [CTX_W-1:0]  ln_ctx;
  logic [FLAG_W-1:0] ln_flags;
  logic              ev_hit, ev_fault, ev_unc;
  logic              accept;

  ctx_keyfold #(.IN_W(KEY_W), .OUT_W(HASH_W)) u_fold (
    .key_i(cur_keyring), .digest_o(key_digest));

  assign cur_ctx = {cur_priv, cur_isa, cur_asid, key_digest};

  ctx_line_store #(.LINES(LINES), .TAG_W(TAG_W), .CTX_W(CTX_W), .FLAG_W(FLAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_en), .wr_idx(fill_line[IDX_W-1:0]), .wr_tag(fill_line[LINE_W-1:IDX_W]),
    .wr_ctx(cur_ctx), .wr_flags(fill_flags),
    .rd_idx(req_line[IDX_W-1:0]),
    .rd_valid(ln_valid), .rd_tag(ln_tag), .rd_ctx(ln_ctx), .rd_flags(ln_flags));

  ctx_hit_eval #(.TAG_W(TAG_W), .CTX_W(CTX_W)) u_eval (
    .line_valid(ln_valid), .line_tag(ln_tag), .line_ctx(ln_ctx), .line_flags(ln_flags),
    .req_tag(req_line[LINE_W-1:IDX_W]), .req_ctx(cur_ctx),
    .req_kind(req_kind), .req_priv(cur_priv),
    .hit_o(ev_hit), .fault_o(ev_fault), .uncached_o(ev_unc));

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_fault    <= 1'b0;
      resp_uncached <= 1'b0;
    end else if (accept) begin
      resp_valid    <= 1'b1;
      resp_hit      <= ev_hit;
      resp_fault    <= ev_fault;
      resp_uncached <= ev_unc;
    end else if (resp_ready) begin
      resp_valid    <= 1'b0;
    end
  end

  // R9: a stalled response holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) &&
                                     $stable(resp_fault) && $stable(resp_uncached)));

  // R11: an accepted request yields a response next edge
  p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R8: outcomes are mutually exclusive
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_hit, resp_fault, resp_uncached}) <= 1);

  // R1: nothing is presented straight out of reset
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(req_valid));
endmodule

// File: tb/ctx_l1_hitchk_tb_top.sv
`timescale 1ns/1ps
module ctx_l1_hitchk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, resp_ready = 1'b1, fill_en = 1'b0;
  logic [25:0] req_line = '0, fill_line = '0;
  logic [1:0]  req_kind = 2'd0, cur_priv = 2'd1, cur_isa = 2'd0;
  logic [15:0] cur_asid = 16'h0010;
  logic [63:0] cur_keyring = 64'h0102030405060708;
  logic [4:0]  fill_flags = '0;
  logic req_ready, resp_valid, resp_hit, resp_fault, resp_uncached;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ctx_l1_hitchk dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_kind(req_kind), .cur_priv(cur_priv), .cur_isa(cur_isa),
    .cur_asid(cur_asid), .cur_keyring(cur_keyring), .fill_en(fill_en),
    .fill_line(fill_line), .fill_flags(fill_flags), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_uncached(resp_uncached));

  localparam logic [3:0] MISS = 4'b1000, HIT = 4'b1100, FLT = 4'b1010, UNC = 4'b1001;

  function automatic logic [25:0] la(input logic [19:0] tag, input logic [5:0] idx);
    return {tag, idx};
  endfunction

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {resp_valid, resp_hit, resp_fault, resp_uncached};
  endfunction

  task automatic fill(input logic [25:0] a, input logic [4:0] fl);
    @(negedge clk);
    fill_en = 1'b1; fill_line = a; fill_flags = fl;
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic look(input logic [25:0] a, input logic [1:0] k, output logic [3:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_line = a; req_kind = k;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = outs();
  endtask

  task automatic t_reset();
    logic [3:0] r;
    chk("R1", "reset valid/ready", {resp_valid, req_ready, 2'b00}, 4'b0100);
    look(la(20'h00000, 6'd0), 2'd0, r);
    chk("R1", "first lookup misses", r, MISS);
    look(la(20'h12345, 6'd63), 2'd2, r);
    chk("R1", "unfilled line misses", r, MISS);
  endtask

  task automatic t_tag();
    logic [3:0] r;
    fill(la(20'h00001, 6'd5), 5'b00000);
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R2", "tag match hits (R11 next-edge)", r, HIT);
    look(la(20'h00002, 6'd5), 2'd0, r);
    chk("R2", "other tag same index misses", r, MISS);
    look(la(20'h00001, 6'd6), 2'd0, r);
    chk("R2", "other index misses", r, MISS);
  endtask

  task automatic t_priv();
    logic [3:0] r;
    cur_priv = 2'd0;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R3", "user vs supervisor fill", r, MISS);
    cur_priv = 2'd2;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R3", "interrupt vs supervisor fill", r, MISS);
    cur_priv = 2'd1;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R3", "same privilege hits", r, HIT);
  endtask

  task automatic t_key();
    logic [3:0] r;
    logic [63:0] k0 = cur_keyring;
    logic [7:0] d0 = 8'h00, d1 = 8'h00;
    logic [63:0] k1 = {k0[63:16], k0[7:0], k0[15:8]};
    for (int i = 0; i < 8; i++) begin d0 ^= k0[i*8 +: 8]; d1 ^= k1[i*8 +: 8]; end
    chk("R4", "bench digests equal", {3'b000, d0 == d1}, 4'b0001);
    cur_keyring = k1;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R4", "same digest still hits", r, HIT);
    cur_keyring = k0 ^ 64'h1;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R4", "digest change misses", r, MISS);
    cur_keyring = k0;
  endtask

  task automatic t_isa_asid();
    logic [3:0] r;
    cur_isa = 2'd1;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R5", "isa mode change misses", r, MISS);
    cur_isa = 2'd0; cur_asid = 16'h0011;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R5", "asid change misses", r, MISS);
    cur_asid = 16'h0010;
    look(la(20'h00001, 6'd5), 2'd0, r);
    chk("R5", "restored context hits", r, HIT);
  endtask

  task automatic t_perm();
    logic [3:0] r;
    fill(la(20'h00A00, 6'd10), 5'b00010);
    look(la(20'h00A00, 6'd10), 2'd1, r);
    chk("R6", "write on no-write faults", r, FLT);
    look(la(20'h00A00, 6'd10), 2'd0, r);
    chk("R6", "read on no-write hits", r, HIT);
    fill(la(20'h00B00, 6'd11), 5'b00100);
    look(la(20'h00B00, 6'd11), 2'd2, r);
    chk("R6", "fetch on no-exec faults", r, FLT);
    look(la(20'h00B00, 6'd11), 2'd1, r);
    chk("R6", "write on no-exec hits", r, HIT);
    fill(la(20'h00C00, 6'd12), 5'b00001);
    look(la(20'h00C00, 6'd12), 2'd0, r);
    chk("R6", "read on no-read faults", r, FLT);
    look(la(20'h00C00, 6'd12), 2'd3, r);
    chk("R6", "kind 3 acts as read", r, FLT);
    look(la(20'h00C00, 6'd12), 2'd1, r);
    chk("R6", "write on no-read hits", r, HIT);
  endtask

  task automatic t_user();
    logic [3:0] r;
    cur_priv = 2'd0;
    fill(la(20'h00D00, 6'd13), 5'b01000);
    look(la(20'h00D00, 6'd13), 2'd0, r);
    chk("R7", "user read on no-user faults", r, FLT);
    look(la(20'h00D00, 6'd13), 2'd2, r);
    chk("R7", "user fetch on no-user faults", r, FLT);
    cur_priv = 2'd1;
    fill(la(20'h00E00, 6'd14), 5'b01000);
    look(la(20'h00E00, 6'd14), 2'd0, r);
    chk("R7", "supervisor on no-user hits", r, HIT);
  endtask

  task automatic t_nocache();
    logic [3:0] r;
    fill(la(20'h00F00, 6'd15), 5'b10010);
    look(la(20'h00F00, 6'd15), 2'd1, r);
    chk("R8", "no-cache wins over no-write", r, UNC);
    look(la(20'h00F00, 6'd15), 2'd0, r);
    chk("R8", "no-cache read passes through", r, UNC);
    look(la(20'h00F01, 6'd15), 2'd0, r);
    chk("R8", "no-cache line other tag misses", r, MISS);
  endtask

  task automatic t_stall();
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_line = la(20'h00001, 6'd5); req_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    req_line = la(20'h00777, 6'd5);
    chk("R9", "response held, ready low", {outs()}, HIT);
    chk("R9", "req_ready low when stalled", {3'b000, req_ready}, 4'b0000);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "still held after second stall cycle", outs(), HIT);
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "waiting request taken on release", outs(), MISS);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "response drains", {resp_valid, 3'b000}, 4'b0000);
  endtask

  task automatic t_same_edge();
    logic [3:0] r;
    fill(la(20'h00100, 6'd20), 5'b00000);
    @(negedge clk);
    fill_en = 1'b1; fill_line = la(20'h00200, 6'd20); fill_flags = 5'b00000;
    req_valid = 1'b1; req_line = la(20'h00100, 6'd20); req_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    chk("R10", "same-edge lookup sees old line", outs(), HIT);
    look(la(20'h00200, 6'd20), 2'd0, r);
    chk("R10", "new tag hits after fill", r, HIT);
    look(la(20'h00100, 6'd20), 2'd0, r);
    chk("R10", "old tag replaced", r, MISS);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tag();
    t_priv();
    t_key();
    t_isa_asid();
    t_perm();
    t_user();
    t_nocache();
    t_stall();
    t_same_edge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog expired: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule